// File: doc/BRIEF.md
# Three-Queue DMA Scheduling Arbiter

This arbiter decides which of three DMA queues owns the transfer engine. Each queue offers a ready flag and a software enable. The winner receives a registered one-hot grant that it keeps until a release point, which is selected by configuration: the end of a request-length chunk, the end of one descriptor, or the end of a whole descriptor chain.

Three scheduling policies are available through static inputs:
- **Fair rotation.** The three queues take turns.
- **Strict priority.** Queue 0 always wins when it is eligible, and may win many times in a row.
- **Interleaved preference.** Queue 0 gets every other slot, and queues 1 and 2 share the remaining slots alternately. With all queues busy the order is q0, q1, q0, q2.

Queues 1 and 2 share a one-bit turn pointer. The pointer moves only when one of those two queues is granted.

Top module: `dma3_sched_arb`

## Requirements
- R1: `grant` has at most one bit set at any time, and it is 3'b000 while reset is asserted and in the cycle after reset.
- R2: A queue is newly granted only if it was both ready and enabled in the cycle before the grant appeared. When no queue is eligible at a rearbitration, `grant` becomes 3'b000. When exactly one queue is eligible, that queue is granted whatever the mode.
- R3: With `fair_mode`=1, grants rotate in the order q0 → q1 → q2 → q0, starting after the last queue granted and skipping queues that are not eligible.
- R4: With `fair_mode`=0 and `q0_strict`=1, queue 0 wins every rearbitration at which it is eligible. This includes the case where it was the previous owner.
- R5: With `fair_mode`=0 and `q0_strict`=0, queue 0 is not granted twice in a row while queue 1 or queue 2 is eligible. With all queues ready, the order is q0, q1, q0, q2, q0, q1.
- R6: Outside fair rotation, a contest between queues 1 and 2 goes to the queue the turn pointer names. The pointer moves to the other queue each time queue 1 or queue 2 is granted. After reset it names queue 1.
- R7: The release pulse is selected as follows: `chain_done` when `rearb_chain`=1 (this overrides `rearb_desc`); `desc_done` when only `rearb_desc`=1; `chunk_done` when both are 0. Pulses on the unselected inputs have no effect.
- R8: While a queue holds the grant, the grant does not change unless the selected release pulse arrives or the owner's enable is cleared. Changes on the ready inputs do not move it.
- R9: If the owner's enable is cleared, the arbiter rearbitrates on the next clock edge. A release pulse that arrives while no grant is active is ignored.
- R10: When the grant changes, the new value appears on the clock edge at which the release (or idle) condition is sampled. An idle arbiter grants on the first edge at which an eligible queue is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_ready | input | 3 | Per-queue request pending |
| q_enable | input | 3 | Per-queue enable |
| fair_mode | input | 1 | 1: equal rotation among all queues |
| q0_strict | input | 1 | When not fair: 1 strict queue-0 priority, 0 interleaved preference |
| rearb_chain | input | 1 | Release at descriptor-chain end (overrides `rearb_desc`) |
| rearb_desc | input | 1 | Release at descriptor end |
| chunk_done | input | 1 | Pulse: request-length chunk finished |
| desc_done | input | 1 | Pulse: descriptor finished |
| chain_done | input | 1 | Pulse: descriptor chain finished |
| grant | output | 3 | One-hot owner; 3'b000 when idle |

## Verification
The block has no parameters, so the bench builds it exactly as described: three queues and one-bit mode inputs. That makes every mode, release-point combination and pointer state reachable within a few dozen cycles. A vector table walks all three policies and all three release points, and covers idle and single-ready cases and enable withdrawal. A long interleaved run then confirms that every queue is served and that queue 0 is never repeated while a neighbour waits.

// File: rtl/dma3_sched_arb.sv
module dma3_sched_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] q_ready,
  input  logic [2:0] q_enable,
  input  logic       fair_mode,
  input  logic       q0_strict,
  input  logic       rearb_chain,
  input  logic       rearb_desc,
  input  logic       chunk_done,
  input  logic       desc_done,
  input  logic       chain_done,
  output logic [2:0] grant
);

  logic [2:0] owner;
  logic [1:0] last;
  logic       turn12;
  logic [2:0] pick;
  logic [2:0] alt12;

  wire [2:0] elig    = q_ready & q_enable;
  wire       release_ev = rearb_chain ? chain_done : (rearb_desc ? desc_done : chunk_done);
  wire       rearb   = (owner == 3'b000) || release_ev || ((owner & ~q_enable) != 3'b000);

  assign grant = owner;

  always_comb begin
    if (turn12)
      alt12 = elig[2] ? 3'b100 : (elig[1] ? 3'b010 : 3'b000);
    else
      alt12 = elig[1] ? 3'b010 : (elig[2] ? 3'b100 : 3'b000);
  end

  always_comb begin
    pick = 3'b000;
    if (fair_mode) begin
      case (last)
        2'd0:    pick = elig[1] ? 3'b010 : elig[2] ? 3'b100 : elig[0] ? 3'b001 : 3'b000;
        2'd1:    pick = elig[2] ? 3'b100 : elig[0] ? 3'b001 : elig[1] ? 3'b010 : 3'b000;
        default: pick = elig[0] ? 3'b001 : elig[1] ? 3'b010 : elig[2] ? 3'b100 : 3'b000;
      endcase
    end else if (elig[0] && (q0_strict || last != 2'd0 || alt12 == 3'b000)) begin
      pick = 3'b001;
    end else begin
      pick = alt12;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner  <= 3'b000;
      last   <= 2'd2;
      turn12 <= 1'b0;
    end else if (rearb) begin
      owner <= pick;
      if (pick != 3'b000) last <= {pick[2], pick[1]};
      if (pick[1]) turn12 <= 1'b1;
      if (pick[2]) turn12 <= 1'b0;
    end
  end

endmodule

// File: rtl/dma3_sched_arb_chk.sv
module dma3_sched_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] q_ready,
  input logic [2:0] q_enable,
  input logic       fair_mode,
  input logic       q0_strict,
  input logic       rearb_chain,
  input logic       rearb_desc,
  input logic       chunk_done,
  input logic       desc_done,
  input logic       chain_done,
  input logic [2:0] grant
);
  logic sel_ev;
  assign sel_ev = rearb_chain ? chain_done : (rearb_desc ? desc_done : chunk_done);

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 3'b000 && grant != $past(grant)) |-> ((grant & $past(q_ready & q_enable)) != 3'b000));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(grant) != 3'b000 && !$past(sel_ev) && (($past(grant) & ~$past(q_enable)) == 3'b000))
      |-> $stable(grant));

  a_r9_disable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~q_enable) != 3'b000) |=> (grant != $past(grant)));

  a_r4_strict_q0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fair_mode && q0_strict && sel_ev && grant != 3'b000 && q_ready[0] && q_enable[0]))
      |-> grant[0]);

  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fair_mode && !q0_strict && sel_ev && grant[0] && ((q_ready[2:1] & q_enable[2:1]) != 2'b00)))
      |-> !grant[0]);
endmodule

bind dma3_sched_arb dma3_sched_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .q_ready(q_ready), .q_enable(q_enable),
  .fair_mode(fair_mode), .q0_strict(q0_strict), .rearb_chain(rearb_chain),
  .rearb_desc(rearb_desc), .chunk_done(chunk_done), .desc_done(desc_done),
  .chain_done(chain_done), .grant(grant)
);

// File: tb/tb_dma3_sched_arb.sv
module tb_dma3_sched_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] q_ready = 3'b000, q_enable = 3'b000;
  logic fair_mode = 1'b0, q0_strict = 1'b0, rearb_chain = 1'b0, rearb_desc = 1'b0;
  logic chunk_done = 1'b0, desc_done = 1'b0, chain_done = 1'b0;
  logic [2:0] grant;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma3_sched_arb dut (.*);

  // {fair,strict,rb_chain,rb_desc}, ready, enable, {chunk,desc,chain}, expected grant
  localparam int NV = 30;
  localparam logic [15:0] VEC [NV] = '{
    {4'b0000,3'b111,3'b111,3'b000,3'b001}, {4'b0000,3'b111,3'b111,3'b100,3'b010},
    {4'b0000,3'b111,3'b111,3'b100,3'b001}, {4'b0000,3'b111,3'b111,3'b100,3'b100},
    {4'b0000,3'b111,3'b111,3'b100,3'b001}, {4'b0000,3'b111,3'b111,3'b100,3'b010},
    {4'b0000,3'b001,3'b111,3'b000,3'b010}, {4'b0000,3'b001,3'b111,3'b010,3'b010},
    {4'b0000,3'b001,3'b111,3'b100,3'b001}, {4'b0000,3'b001,3'b111,3'b100,3'b001},
    {4'b0000,3'b000,3'b111,3'b100,3'b000}, {4'b0000,3'b000,3'b111,3'b100,3'b000},
    {4'b0100,3'b111,3'b111,3'b000,3'b001}, {4'b0100,3'b111,3'b111,3'b100,3'b001},
    {4'b0100,3'b110,3'b111,3'b100,3'b100}, {4'b0100,3'b110,3'b111,3'b100,3'b010},
    {4'b1000,3'b111,3'b111,3'b100,3'b100}, {4'b1000,3'b111,3'b111,3'b100,3'b001},
    {4'b1000,3'b111,3'b111,3'b100,3'b010}, {4'b1000,3'b111,3'b101,3'b100,3'b100},
    {4'b1000,3'b111,3'b101,3'b100,3'b001}, {4'b1000,3'b111,3'b101,3'b100,3'b100},
    {4'b1001,3'b111,3'b111,3'b100,3'b100}, {4'b1001,3'b111,3'b111,3'b001,3'b100},
    {4'b1001,3'b111,3'b111,3'b010,3'b001}, {4'b1011,3'b111,3'b111,3'b010,3'b001},
    {4'b1011,3'b111,3'b111,3'b001,3'b010}, {4'b1011,3'b111,3'b101,3'b000,3'b100},
    {4'b0000,3'b111,3'b111,3'b100,3'b001}, {4'b0000,3'b111,3'b111,3'b100,3'b010}
  };

  function automatic string tag(input int i);
    if (i < 6)  return "R5";
    if (i < 8)  return "R8";
    if (i < 10) return "R2";
    if (i == 10) return "R2";
    if (i == 11) return "R9";
    if (i < 14) return "R4";
    if (i < 16) return "R6";
    if (i < 22) return "R3";
    if (i < 27) return "R7";
    if (i == 27) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: grant=%b expected=finish", grant);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt[3];
    logic [2:0] prev;
    @(negedge clk);
    check("R1", grant, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", grant, 3'b000);

    for (int i = 0; i < NV; i++) begin
      {fair_mode, q0_strict, rearb_chain, rearb_desc} = VEC[i][15:12];
      q_ready  = VEC[i][11:9];
      q_enable = VEC[i][8:6];
      {chunk_done, desc_done, chain_done} = VEC[i][5:3];
      @(negedge clk);
      check(tag(i), grant, VEC[i][2:0]);
    end

    // R5/R6: long interleaved run, every queue served, q0 never back-to-back
    {fair_mode, q0_strict, rearb_chain, rearb_desc} = 4'b0000;
    q_ready = 3'b111; q_enable = 3'b111;
    {chunk_done, desc_done, chain_done} = 3'b100;
    cnt = '{0, 0, 0};
    prev = grant;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (prev[0] && grant[0]) check("R5", grant, 3'b010);
      for (int q = 0; q < 3; q++) if (grant[q]) cnt[q]++;
      prev = grant;
    end
    check("R5", (cnt[0] == 20) ? 3'b001 : 3'b000, 3'b001);
    check("R6", (cnt[1] == 10 && cnt[2] == 10) ? 3'b001 : 3'b000, 3'b001);

    // R1: reset while granted returns to idle
    {chunk_done, desc_done, chain_done} = 3'b000;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", grant, 3'b000);
    rst_n = 1'b1;
    q_ready = 3'b100;
    @(negedge clk);
    check("R10", grant, 3'b100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule